// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block picks the receive mailbox that takes an incoming CAN frame, or reports that no mailbox takes it. A frame is offered as a 29-bit identifier with its format flag (standard or extended) and its frame-type flag (data or remote), qualified by a one-cycle valid strobe. Thirty-two mailboxes each carry a reference identifier, a format bit, a frame-type bit and a receive enable. Eight mask words are each shared by a run of four consecutive mailboxes. Masking can be switched off for any single mailbox, and that mailbox then needs an exact identifier match.

A global format mode accepts only standard frames, only extended frames, or both. In the mixed setting each mailbox's format bit must agree with the frame. A FIFO mode turns the top four mailboxes into one receive FIFO. The FIFO has two identifier sets of its own, each with its own format and frame-type qualifier. It takes a frame that passes either set, so it can accept two identifier ranges, both formats, or both frame types. The result is registered and appears one clock after the strobe as a hit pulse, the winning mailbox index and a FIFO flag.

Top module: `can_acc_filter`

## Requirements
- R1: Mask word k (k = 0..7, packed at bits 29k+28..29k of `grp_mask`) applies to mailboxes 4k..4k+3. A mask bit of 1 makes the identifier bit take part in the comparison. A mask bit of 0 makes that bit don't-care.
- R2: When `mask_off[m]` is 1, mailbox m ignores its group mask and needs every compared identifier bit to equal its reference.
- R3: For a standard frame (`frm_ide` = 0) only identifier bits 28..18 are compared. Bits 17..0 of both the frame and the reference have no effect.
- R4: `cfg_fmt` = 00 accepts only standard frames and 01 accepts only extended frames; in both settings the mailbox format bit is ignored. `cfg_fmt` = 10 or 11 is mixed: a frame is accepted only when its `frm_ide` equals the mailbox format bit.
- R5: A mailbox accepts a frame only when `frm_rtr` equals the mailbox frame-type bit (0 = data frame, 1 = remote frame).
- R6: Only mailboxes with `mb_rx_en` set are candidates. Among the matching candidates, the lowest-numbered one wins, and its index appears on `acc_idx`.
- R7: After reset `acc_hit`, `acc_fifo` and `acc_idx` are 0. The outputs show the result for the frame sampled with `frm_valid` at the previous rising edge. After a cycle with `frm_valid` low, `acc_hit` is 0 and `acc_idx` is 0.
- R8: With `cfg_fifo_en` = 1, mailboxes 24..27 never accept. The reference identifier, format bit, frame-type bit and `mask_off` bit of mailboxes 28..31 have no effect.
- R9: With `cfg_fifo_en` = 1 and `mb_rx_en[28]` = 1, the FIFO accepts a frame that matches set A under mask word 6 or set B under mask word 7. Each set applies its own format and frame-type bits under the rules of R3..R5. A FIFO hit reports index 28 with `acc_fifo` = 1, and any matching mailbox 0..23 takes priority over it.
- R10: With `cfg_fifo_en` = 0, `acc_fifo` is always 0 and mailboxes 24..31 filter like all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame strobe, one cycle per frame |
| frm_id | input | 29 | Frame identifier; a standard ID sits in bits 28..18 |
| frm_ide | input | 1 | Frame format: 0 standard, 1 extended |
| frm_rtr | input | 1 | Frame type: 0 data, 1 remote |
| cfg_fmt | input | 2 | Format mode: 00 standard, 01 extended, 1x mixed |
| cfg_fifo_en | input | 1 | Receive FIFO mode on mailboxes 28..31 |
| mb_id | input | 928 | Reference identifiers, mailbox m at bits 29m+28..29m |
| mb_ide | input | 32 | Per-mailbox format bit |
| mb_rtr | input | 32 | Per-mailbox frame-type bit |
| mb_rx_en | input | 32 | Per-mailbox receive enable; bit 28 enables the FIFO |
| mask_off | input | 32 | Per-mailbox mask disable |
| grp_mask | input | 232 | Eight 29-bit group masks |
| fifo_id_a | input | 29 | FIFO set A identifier (mask word 6) |
| fifo_ide_a | input | 1 | FIFO set A format bit |
| fifo_rtr_a | input | 1 | FIFO set A frame-type bit |
| fifo_id_b | input | 29 | FIFO set B identifier (mask word 7) |
| fifo_ide_b | input | 1 | FIFO set B format bit |
| fifo_rtr_b | input | 1 | FIFO set B frame-type bit |
| acc_hit | output | 1 | A mailbox or the FIFO accepted the frame |
| acc_idx | output | 5 | Winning mailbox index; 28 for a FIFO hit |
| acc_fifo | output | 1 | The receive FIFO accepted the frame |

## Verification
The assertions assume that the configuration ports hold steady across the cycle in which a frame is sampled. They also assume that `frm_valid` is a clean synchronous level and never X after reset. The bench changes configuration only while no frame is in flight, and drives every input on the falling edge. It runs directed frames for each rule and then many rounds of randomized configurations. The randomized identifiers are drawn from a small pool with perturbed bits, so hits, near misses and multi-mailbox ties all occur often, and an arithmetic model in the bench predicts each outcome.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef enum logic [1:0] {
        FMT_STD_ONLY = 2'b00,
        FMT_EXT_ONLY = 2'b01,
        FMT_MIXED    = 2'b10,
        FMT_MIXED_B  = 2'b11
    } fmt_e;

    // Bits of the identifier that a frame of the given format carries.
    function automatic logic [ID_W-1:0] fmt_bits(input logic ext);
        fmt_bits = ext ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};
    endfunction

    // Format acceptance: in mixed mode the slot bit decides, else the mode does.
    function automatic logic fmt_pass(input logic [1:0] fmt, input logic frame_ext,
                                      input logic slot_ext);
        fmt_pass = fmt[1] ? (frame_ext == slot_ext) : (frame_ext == fmt[0]);
    endfunction

endpackage

// File: rtl/acf_id_cmp.sv
module acf_id_cmp
    import can_acf_pkg::*;
(
    input  logic [ID_W-1:0] frame_id,
    input  logic            frame_ext,
    input  logic            frame_rmt,
    input  logic [ID_W-1:0] ref_id,
    input  logic            ref_ext,
    input  logic            ref_rmt,
    input  logic [ID_W-1:0] care_mask,
    input  logic [1:0]      fmt,
    output logic            match
);
    logic [ID_W-1:0] cmp_bits_d;
    logic            id_eq_d;

    always_comb begin
        cmp_bits_d = care_mask & fmt_bits(frame_ext);
        id_eq_d    = ((frame_id ^ ref_id) & cmp_bits_d) == '0;
        match      = id_eq_d
                   & (frame_rmt == ref_rmt)
                   & fmt_pass(fmt, frame_ext, ref_ext);
    end

endmodule

// File: rtl/acf_mb_bank.sv
module acf_mb_bank
    import can_acf_pkg::*;
#(
    parameter int NUM_MB      = 32,
    parameter int MB_PER_MASK = 4,
    localparam int NUM_MASK   = NUM_MB / MB_PER_MASK,
    localparam int DEAD_BASE  = NUM_MB - 2 * MB_PER_MASK
) (
    input  logic [ID_W-1:0]          frame_id,
    input  logic                     frame_ext,
    input  logic                     frame_rmt,
    input  logic [1:0]               fmt,
    input  logic                     fifo_en,
    input  logic [NUM_MB*ID_W-1:0]   mb_id,
    input  logic [NUM_MB-1:0]        mb_ide,
    input  logic [NUM_MB-1:0]        mb_rtr,
    input  logic [NUM_MB-1:0]        mb_rx_en,
    input  logic [NUM_MB-1:0]        mask_off,
    input  logic [NUM_MASK*ID_W-1:0] grp_mask,
    output logic [NUM_MB-1:0]        slot_match
);
    for (genvar m = 0; m < NUM_MB; m++) begin : g_slot
        localparam int  GRP       = m / MB_PER_MASK;
        localparam bit  FIFO_ZONE = (m >= DEAD_BASE);

        logic [ID_W-1:0] eff_mask_d;
        logic            raw_match;
        logic            eligible_d;

        always_comb begin
            eff_mask_d = mask_off[m] ? {ID_W{1'b1}} : grp_mask[GRP*ID_W +: ID_W];
            eligible_d = mb_rx_en[m] & ~(fifo_en & FIFO_ZONE);
        end

        acf_id_cmp u_cmp (
            .frame_id  (frame_id),
            .frame_ext (frame_ext),
            .frame_rmt (frame_rmt),
            .ref_id    (mb_id[m*ID_W +: ID_W]),
            .ref_ext   (mb_ide[m]),
            .ref_rmt   (mb_rtr[m]),
            .care_mask (eff_mask_d),
            .fmt       (fmt),
            .match     (raw_match)
        );

        assign slot_match[m] = eligible_d & raw_match;
    end

endmodule

// File: rtl/acf_fifo_match.sv
module acf_fifo_match
    import can_acf_pkg::*;
(
    input  logic [ID_W-1:0] frame_id,
    input  logic            frame_ext,
    input  logic            frame_rmt,
    input  logic [1:0]      fmt,
    input  logic            fifo_en,
    input  logic            fifo_rx_en,
    input  logic [ID_W-1:0] mask_a,
    input  logic [ID_W-1:0] mask_b,
    input  logic [ID_W-1:0] id_a,
    input  logic            ide_a,
    input  logic            rtr_a,
    input  logic [ID_W-1:0] id_b,
    input  logic            ide_b,
    input  logic            rtr_b,
    output logic            fifo_hit
);
    logic [1:0] set_match;

    acf_id_cmp u_set_a (
        .frame_id  (frame_id),
        .frame_ext (frame_ext),
        .frame_rmt (frame_rmt),
        .ref_id    (id_a),
        .ref_ext   (ide_a),
        .ref_rmt   (rtr_a),
        .care_mask (mask_a),
        .fmt       (fmt),
        .match     (set_match[0])
    );

    acf_id_cmp u_set_b (
        .frame_id  (frame_id),
        .frame_ext (frame_ext),
        .frame_rmt (frame_rmt),
        .ref_id    (id_b),
        .ref_ext   (ide_b),
        .ref_rmt   (rtr_b),
        .care_mask (mask_b),
        .fmt       (fmt),
        .match     (set_match[1])
    );

    assign fifo_hit = fifo_en & fifo_rx_en & (|set_match);

endmodule

// File: rtl/acf_pick.sv
module acf_pick #(
    parameter int N   = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] lowest_d;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
        any      = |cand;
        lowest_d = cand & (~cand + 1'b1);
    end

    // R6: exactly one winner at most, and it is the reported one
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lowest_d) && (any == ($countones(lowest_d) == 1)));

    p_winner_is_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((lowest_d >> idx) == 1));

endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
    import can_acf_pkg::*;
#(
    parameter int NUM_MB      = 32,
    parameter int MB_PER_MASK = 4,
    localparam int NUM_MASK   = NUM_MB / MB_PER_MASK,
    localparam int IDX_W      = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frm_valid,
    input  logic [ID_W-1:0]          frm_id,
    input  logic                     frm_ide,
    input  logic                     frm_rtr,
    input  logic [1:0]               cfg_fmt,
    input  logic                     cfg_fifo_en,
    input  logic [NUM_MB*ID_W-1:0]   mb_id,
    input  logic [NUM_MB-1:0]        mb_ide,
    input  logic [NUM_MB-1:0]        mb_rtr,
    input  logic [NUM_MB-1:0]        mb_rx_en,
    input  logic [NUM_MB-1:0]        mask_off,
    input  logic [NUM_MASK*ID_W-1:0] grp_mask,
    input  logic [ID_W-1:0]          fifo_id_a,
    input  logic                     fifo_ide_a,
    input  logic                     fifo_rtr_a,
    input  logic [ID_W-1:0]          fifo_id_b,
    input  logic                     fifo_ide_b,
    input  logic                     fifo_rtr_b,
    output logic                     acc_hit,
    output logic [IDX_W-1:0]         acc_idx,
    output logic                     acc_fifo
);
    localparam int FIFO_BASE = NUM_MB - MB_PER_MASK;
    localparam int DEAD_BASE = NUM_MB - 2 * MB_PER_MASK;

    typedef struct packed {
        logic             hit;
        logic             fifo;
        logic [IDX_W-1:0] idx;
    } res_t;

    res_t st_d, st_q;

    logic [NUM_MB-1:0] slot_match;
    logic [NUM_MB-1:0] cand_d;
    logic              fifo_hit;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;

    acf_mb_bank #(
        .NUM_MB      (NUM_MB),
        .MB_PER_MASK (MB_PER_MASK)
    ) u_bank (
        .frame_id   (frm_id),
        .frame_ext  (frm_ide),
        .frame_rmt  (frm_rtr),
        .fmt        (cfg_fmt),
        .fifo_en    (cfg_fifo_en),
        .mb_id      (mb_id),
        .mb_ide     (mb_ide),
        .mb_rtr     (mb_rtr),
        .mb_rx_en   (mb_rx_en),
        .mask_off   (mask_off),
        .grp_mask   (grp_mask),
        .slot_match (slot_match)
    );

    acf_fifo_match u_fifo (
        .frame_id   (frm_id),
        .frame_ext  (frm_ide),
        .frame_rmt  (frm_rtr),
        .fmt        (cfg_fmt),
        .fifo_en    (cfg_fifo_en),
        .fifo_rx_en (mb_rx_en[FIFO_BASE]),
        .mask_a     (grp_mask[(NUM_MASK-2)*ID_W +: ID_W]),
        .mask_b     (grp_mask[(NUM_MASK-1)*ID_W +: ID_W]),
        .id_a       (fifo_id_a),
        .ide_a      (fifo_ide_a),
        .rtr_a      (fifo_rtr_a),
        .id_b       (fifo_id_b),
        .ide_b      (fifo_ide_b),
        .rtr_b      (fifo_rtr_b),
        .fifo_hit   (fifo_hit)
    );

    always_comb begin
        cand_d            = slot_match;
        cand_d[FIFO_BASE] = slot_match[FIFO_BASE] | fifo_hit;
    end

    acf_pick #(.N(NUM_MB)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand_d),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d      = '0;
        st_d.hit  = frm_valid & pick_any;
        st_d.idx  = st_d.hit ? pick_idx : '0;
        st_d.fifo = st_d.hit & cfg_fifo_en & (pick_idx == IDX_W'(FIFO_BASE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_hit  = st_q.hit;
    assign acc_idx  = st_q.idx;
    assign acc_fifo = st_q.fifo;

    // R7: no strobe, no hit on the next cycle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> (!acc_hit && acc_idx == '0));

    // R6: a winner was receive-enabled when the frame was sampled
    p_winner_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> ((($past(mb_rx_en) >> acc_idx) & 1) != 0));

    // R9: a FIFO hit always reports the FIFO slot
    p_fifo_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fifo |-> (acc_hit && acc_idx == IDX_W'(FIFO_BASE)));

    // R8: in FIFO mode no ordinary win comes from the upper two groups
    p_dead_slots_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && frm_valid) |=>
            !(acc_hit && !acc_fifo && acc_idx >= IDX_W'(DEAD_BASE)));

    // R10: outside FIFO mode the FIFO flag stays low
    p_no_fifo_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |=> !acc_fifo);

endmodule

// File: tb/can_acc_filter_tb_top.sv
module can_acc_filter_tb_top;

    localparam int NMB = 32;
    localparam int IW  = 29;
    localparam logic [28:0] STD_BITS = 29'h1FFC0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic frm_ide = 1'b0, frm_rtr = 1'b0;
    logic [1:0] cfg_fmt = 2'b01;
    logic cfg_fifo_en = 1'b0;
    logic [NMB*IW-1:0] mb_id = '0;
    logic [NMB-1:0] mb_ide = '0, mb_rtr = '0, mb_rx_en = '0, mask_off = '0;
    logic [8*IW-1:0] grp_mask = '0;
    logic [28:0] fifo_id_a = '0, fifo_id_b = '0;
    logic fifo_ide_a = 1'b0, fifo_rtr_a = 1'b0, fifo_ide_b = 1'b0, fifo_rtr_b = 1'b0;
    logic acc_hit, acc_fifo;
    logic [4:0] acc_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_acc_filter dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ide(frm_ide), .frm_rtr(frm_rtr), .cfg_fmt(cfg_fmt),
        .cfg_fifo_en(cfg_fifo_en), .mb_id(mb_id), .mb_ide(mb_ide),
        .mb_rtr(mb_rtr), .mb_rx_en(mb_rx_en), .mask_off(mask_off),
        .grp_mask(grp_mask), .fifo_id_a(fifo_id_a), .fifo_ide_a(fifo_ide_a),
        .fifo_rtr_a(fifo_rtr_a), .fifo_id_b(fifo_id_b), .fifo_ide_b(fifo_ide_b),
        .fifo_rtr_b(fifo_rtr_b), .acc_hit(acc_hit), .acc_idx(acc_idx),
        .acc_fifo(acc_fifo)
    );

    function automatic bit set_ok(input logic [28:0] id, input logic ide, input logic rtr,
                                  input logic [28:0] rid, input logic rext,
                                  input logic rrmt, input logic [28:0] msk);
        logic [28:0] care;
        bit fmt_ok;
        care   = ide ? msk : (msk & STD_BITS);
        fmt_ok = (cfg_fmt >= 2) ? (ide == rext) : (ide == cfg_fmt[0]);
        return fmt_ok && (rtr == rrmt) && (((id ^ rid) & care) == 0);
    endfunction

    // Returns {hit, fifo, idx}
    function automatic logic [6:0] model(input logic [28:0] id, input logic ide,
                                         input logic rtr);
        for (int m = 0; m < NMB; m++) begin
            logic [28:0] msk;
            if (cfg_fifo_en && m >= 24) break;
            if (!mb_rx_en[m]) continue;
            msk = mask_off[m] ? 29'h1FFFFFFF : grp_mask[(m/4)*IW +: IW];
            if (set_ok(id, ide, rtr, mb_id[m*IW +: IW], mb_ide[m], mb_rtr[m], msk))
                return {1'b1, 1'b0, 5'(m)};
        end
        if (cfg_fifo_en && mb_rx_en[28] &&
            (set_ok(id, ide, rtr, fifo_id_a, fifo_ide_a, fifo_rtr_a, grp_mask[6*IW +: IW]) ||
             set_ok(id, ide, rtr, fifo_id_b, fifo_ide_b, fifo_rtr_b, grp_mask[7*IW +: IW])))
            return {1'b1, 1'b1, 5'd28};
        return 7'd0;
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act hit=%0b fifo=%0b idx=%0d exp hit=%0b fifo=%0b idx=%0d",
                     tag, act[6], act[5], act[4:0], exp[6], exp[5], exp[4:0]);
        end
    endtask

    task automatic set_mb(input int m, input logic [28:0] id, input logic ide,
                          input logic rtr, input logic rx);
        mb_id[m*IW +: IW] = id;
        mb_ide[m] = ide;
        mb_rtr[m] = rtr;
        mb_rx_en[m] = rx;
    endtask

    // Offer one frame; compare against a fixed expectation and the model.
    task automatic frame(input string tag, input logic [28:0] id, input logic ide,
                         input logic rtr, input logic [6:0] exp, input bit use_exp);
        logic [6:0] want;
        @(negedge clk);
        frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_valid = 1'b1;
        want = use_exp ? exp : model(id, ide, rtr);
        @(negedge clk);
        check(tag, {acc_hit, acc_fifo, acc_idx}, want);
        frm_valid = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        @(negedge clk);
        check(tag, {acc_hit, acc_fifo, acc_idx}, 7'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset", {acc_hit, acc_fifo, acc_idx}, 7'd0);
        rst_n = 1'b1;

        // Normal mode, extended only
        cfg_fmt = 2'b01;
        grp_mask[0*IW +: IW] = 29'h1FFFFFFF;
        grp_mask[1*IW +: IW] = 29'h1FFFFFF0;
        set_mb(1, 29'h0ABCDE12, 1'b1, 1'b0, 1'b1);
        set_mb(5, 29'h0ABCDE12, 1'b1, 1'b0, 1'b1);
        frame("R6 lowest wins", 29'h0ABCDE12, 1'b1, 1'b0, {2'b10, 5'd1}, 1);
        frame("R1 group mask dont-care", 29'h0ABCDE1F, 1'b1, 1'b0, {2'b10, 5'd5}, 1);
        frame("R1 group mask compare", 29'h0ABCDF12, 1'b1, 1'b0, 7'd0, 1);
        idle_check("R7 idle after frame");
        mask_off[5] = 1'b1;
        frame("R2 mask off exact", 29'h0ABCDE1F, 1'b1, 1'b0, 7'd0, 1);
        mb_rx_en[1] = 1'b0;
        frame("R6 disabled slot skipped", 29'h0ABCDE12, 1'b1, 1'b0, {2'b10, 5'd5}, 1);
        frame("R5 remote vs data", 29'h0ABCDE12, 1'b1, 1'b1, 7'd0, 1);
        mb_rtr[5] = 1'b1;
        frame("R5 remote accepted", 29'h0ABCDE12, 1'b1, 1'b1, {2'b10, 5'd5}, 1);
        cfg_fmt = 2'b00;
        frame("R4 std-only rejects ext", 29'h0ABCDE12, 1'b1, 1'b1, 7'd0, 1);
        frame("R3 std compares top bits", 29'h0ABC0000, 1'b0, 1'b1, {2'b10, 5'd5}, 1);
        frame("R3 std top bit differs", 29'h0AFC0000, 1'b0, 1'b1, 7'd0, 1);
        cfg_fmt = 2'b10;
        frame("R4 mixed needs ide match", 29'h0ABCDE12, 1'b0, 1'b1, 7'd0, 1);
        frame("R4 mixed ext accepted", 29'h0ABCDE12, 1'b1, 1'b1, {2'b10, 5'd5}, 1);

        // FIFO mode, mixed formats
        cfg_fifo_en = 1'b1;
        grp_mask[6*IW +: IW] = 29'h1FF00000;
        grp_mask[7*IW +: IW] = 29'h1FFFFF00;
        set_mb(26, 29'h00000123, 1'b1, 1'b0, 1'b1);
        frame("R8 slot 26 idle in fifo mode", 29'h00000123, 1'b1, 1'b0, 7'd0, 1);
        set_mb(28, 29'h00000000, 1'b1, 1'b1, 1'b1);
        fifo_id_a = 29'h00100000; fifo_ide_a = 1'b0; fifo_rtr_a = 1'b0;
        fifo_id_b = 29'h05555555; fifo_ide_b = 1'b1; fifo_rtr_b = 1'b1;
        frame("R9 set A std range", 29'h00130000, 1'b0, 1'b0, {2'b11, 5'd28}, 1);
        frame("R9 set B ext remote", 29'h055555AA, 1'b1, 1'b1, {2'b11, 5'd28}, 1);
        frame("R9 no set matches", 29'h055555AA, 1'b1, 1'b0, 7'd0, 1);
        set_mb(3, 29'h00130000, 1'b0, 1'b0, 1'b1);
        frame("R9 mailbox beats fifo", 29'h00130000, 1'b0, 1'b0, {2'b10, 5'd3}, 1);
        mask_off[28] = 1'b1;
        frame("R8 fifo ignores mask off", 29'h00170000, 1'b0, 1'b0, {2'b11, 5'd28}, 1);
        mb_rx_en[28] = 1'b0;
        frame("R9 fifo disabled", 29'h00170000, 1'b0, 1'b0, 7'd0, 1);
        cfg_fifo_en = 1'b0;
        frame("R10 slot 26 in normal mode", 29'h00000123, 1'b1, 1'b0, {2'b10, 5'd26}, 1);

        // Randomized sweeps against the model
        for (int round = 0; round < 40; round++) begin
            logic [28:0] pool [4];
            for (int p = 0; p < 4; p++) pool[p] = 29'($urandom);
            @(negedge clk);
            cfg_fmt = 2'($urandom);
            cfg_fifo_en = 1'($urandom);
            for (int m = 0; m < NMB; m++) begin
                set_mb(m, pool[$urandom % 4] ^ 29'($urandom & 32'h3), 1'($urandom),
                       1'($urandom), ($urandom % 3) == 0);
                mask_off[m] = ($urandom % 4) == 0;
            end
            for (int k = 0; k < 8; k++) begin
                case ($urandom % 3)
                    0: grp_mask[k*IW +: IW] = 29'h1FFFFFFF;
                    1: grp_mask[k*IW +: IW] = 29'h1FFFFFF0;
                    default: grp_mask[k*IW +: IW] = 29'($urandom) | 29'h1FFC0000;
                endcase
            end
            fifo_id_a = pool[0]; fifo_ide_a = 1'($urandom); fifo_rtr_a = 1'($urandom);
            fifo_id_b = pool[1]; fifo_ide_b = 1'($urandom); fifo_rtr_b = 1'($urandom);
            for (int f = 0; f < 120; f++) begin
                logic [28:0] fid;
                fid = pool[$urandom % 4] ^ 29'($urandom & 32'h0000_000F);
                if (($urandom % 8) == 0) fid = fid ^ 29'h00040000;
                frame("R6 R8 R9 sweep", fid, 1'($urandom), 1'($urandom), 7'd0, 0);
            end
            idle_check("R7 idle after sweep");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule